// File: doc/BRIEF.md
# Split-Path Pipeline Interlock Unit

This unit is the hazard-detection and operand-forwarding control for an in-order pipeline. The pipeline runs Fetch, Decode and Regread, and then splits. Integer adds take IntALU and then Regwrite. Loads and stores take IntALU, two Datamem cycles, and then Regwrite. A register read takes one whole cycle, and so does a register write. A consumer therefore cannot read a register in the cycle that its producer writes it.

The unit sits in Decode. It takes one decoded instruction per cycle over a valid/ready handshake. It keeps its own record of every instruction it has let into Regread, and follows each record down the path of that instruction's class. It holds a dependent instruction in Decode for the number of cycles the selected mode needs, and sends a bubble into Regread for each held cycle. When an instruction issues, the unit also states where each source operand will come from. Mode `bypass_en` chooses between two behaviours: operands come only from the register file, or results are forwarded from the end of IntALU and from the end of the second Datamem stage.

Back-pressure rules: `in_ready` is low exactly when `stall` is high. `stall` can only be high while `in_valid` is high. An instruction issues on a rising edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the sender must hold every input field stable. A cycle with `in_valid` low sends a bubble down the pipeline.

Top module: `ilk_unit`

## Requirements
- R1: After reset no instruction is in flight. A valid instruction is accepted at once (`stall`=0, `in_ready`=1), with both selects 0.
- R2: With bypass off, an add followed directly by a consumer of its destination stalls exactly 2 cycles.
- R3: With bypass off, a load followed directly by a consumer of its destination stalls exactly 4 cycles. This holds for either operand, including a store's data operand. No run of stall cycles is longer than 4.
- R4: With bypass on, a consumer directly behind a dependent add does not stall. The operand that matches gets select 1 (forward from IntALU).
- R5: With bypass on, an add or load directly behind a dependent load stalls 2 cycles. When it issues, the operand that matches gets select 2 (forward from memory).
- R6: A store's address operand (src_a) is needed at IntALU, and its data operand (src_b) is needed at the first Datamem stage. With bypass on, a store directly behind a load stalls 2 cycles on an address match and 1 cycle on a data match.
- R7: Register 0 never causes a stall, whether it is a source or a destination.
- R8: The youngest in-flight producer of a register decides the stall and the select. An older producer of the same register is ignored.
- R9: Bubble cycles (in_valid=0) between a producer and its consumer count toward the distance. For example, with bypass off, a load then 2 bubbles then a consumer stalls 2 cycles. With bypass on, a load then 1 bubble then a consumer stalls 1 cycle.
- R10: Stores (class 3) and no-ops (class 0) never act as producers, whatever their destination field holds. Adds are class 1 and loads are class 2. A no-op reads no source, an add reads both sources, and a load reads src_a only.
- R11: With bypass off, both selects are always 0 (register file).
- R12: `stall` is 0 whenever `in_valid` is 0. `in_ready` equals the inverse of `stall`. Each stalled cycle puts a bubble into Regread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | 1 = full forwarding, 0 = register file only |
| in_valid | input | 1 | Decode holds an instruction |
| in_ready | output | 1 | Instruction may leave Decode this cycle |
| in_class | input | 2 | 0 no-op, 1 add, 2 load, 3 store |
| in_src_a | input | REG_AW | First source (address for loads and stores) |
| in_src_b | input | REG_AW | Second source (store data for stores) |
| in_dst | input | REG_AW | Destination register |
| stall | output | 1 | Hold Fetch and Decode, bubble into Regread |
| sel_a | output | 2 | Source of operand a: 0 register file, 1 IntALU forward, 2 memory forward |
| sel_b | output | 2 | Source of operand b, same encoding |

## Verification
On every cycle, the embedded assertions check the following: the handshake relation between `stall` and `in_valid`; that a bubble enters Regread after each stall; that no run of stall cycles exceeds 4; that instructions reading only register 0 are never held; and that the selects stay 0 with bypass off. The exact stall counts for each pairing of producer class, consumer class, operand position, mode and gap can only be shown by the bench's scenarios. The same holds for the select values at issue and for the rule that the youngest producer wins.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int NUM_SLOTS = 6;
  localparam int CW        = 3;

  // slots ordered youngest to oldest; M1 and WA are never both filled
  localparam int S_R  = 0;
  localparam int S_X  = 1;
  localparam int S_M1 = 2;
  localparam int S_WA = 3;
  localparam int S_M2 = 4;
  localparam int S_WM = 5;

  typedef enum logic [1:0] {
    CL_NOP   = 2'd0,
    CL_ADD   = 2'd1,
    CL_LOAD  = 2'd2,
    CL_STORE = 2'd3
  } ins_class_e;

  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_ALU  = 2'd1,
    SEL_LOAD = 2'd2
  } byp_sel_e;

  // slot feeding each slot on the next edge
  function automatic int src_of(input int s);
    case (s)
      S_X:     return S_R;
      S_M1:    return S_X;
      S_WA:    return S_X;
      S_M2:    return S_M1;
      S_WM:    return S_M2;
      default: return S_R;
    endcase
  endfunction

  // cycles until the producer's register write completes
  function automatic logic [CW-1:0] write_dist(input int s, input logic is_ld);
    case (s)
      S_R:     return is_ld ? 3'd4 : 3'd2;
      S_X:     return is_ld ? 3'd3 : 3'd1;
      S_M1:    return 3'd2;
      S_M2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // cycles until the result leaves its producing stage (0 = already out)
  function automatic logic [CW-1:0] avail_dist(input int s, input logic is_ld);
    case (s)
      S_R:     return is_ld ? 3'd3 : 3'd1;
      S_X:     return is_ld ? 3'd2 : 3'd0;
      S_M1:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ilk_track.sv
module ilk_track
  import ilk_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [1:0]           in_class,
  input  logic [REG_AW-1:0]    in_dst,
  output logic [NUM_SLOTS-1:0] slot_wr,
  output logic [NUM_SLOTS-1:0] slot_ld,
  output logic [REG_AW-1:0]    slot_dst  [NUM_SLOTS],
  output logic [CW-1:0]        slot_wcnt [NUM_SLOTS],
  output logic [CW-1:0]        slot_acnt [NUM_SLOTS],
  output logic                 r_valid
);
  logic [NUM_SLOTS-1:0] vld, mem, wr, ld;
  logic [REG_AW-1:0]    dst [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] take;

  logic cls_mem, cls_wr, cls_ld;
  assign cls_ld  = (in_class == CL_LOAD);
  assign cls_mem = (in_class == CL_LOAD) || (in_class == CL_STORE);
  assign cls_wr  = (in_class == CL_ADD) || (in_class == CL_LOAD);

  // path split after IntALU: memory classes go to M1, others to WA
  always_comb begin
    take = '0;
    for (int s = 1; s < NUM_SLOTS; s++) begin
      if (s == S_M1)      take[s] = vld[S_X] && mem[S_X];
      else if (s == S_WA) take[s] = vld[S_X] && !mem[S_X];
      else                take[s] = vld[src_of(s)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      mem <= '0;
      wr  <= '0;
      ld  <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) dst[s] <= '0;
    end else begin
      vld[S_R] <= issue;
      mem[S_R] <= issue && cls_mem;
      wr[S_R]  <= issue && cls_wr && (in_dst != '0);
      ld[S_R]  <= issue && cls_ld;
      dst[S_R] <= in_dst;
      for (int s = 1; s < NUM_SLOTS; s++) begin
        vld[s] <= take[s];
        mem[s] <= take[s] && mem[src_of(s)];
        wr[s]  <= take[s] && wr[src_of(s)];
        ld[s]  <= take[s] && ld[src_of(s)];
        dst[s] <= dst[src_of(s)];
      end
    end
  end

  assign slot_wr = wr;
  assign slot_ld = ld;
  assign r_valid = vld[S_R];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dist
    assign slot_dst[g]  = dst[g];
    assign slot_wcnt[g] = write_dist(g, ld[g]);
    assign slot_acnt[g] = avail_dist(g, ld[g]);
  end
endmodule

// File: rtl/ilk_opchk.sv
module ilk_opchk
  import ilk_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass_en,
  input  logic                 used,
  input  logic                 late,
  input  logic [REG_AW-1:0]    src,
  input  logic [NUM_SLOTS-1:0] slot_wr,
  input  logic [NUM_SLOTS-1:0] slot_ld,
  input  logic [REG_AW-1:0]    slot_dst  [NUM_SLOTS],
  input  logic [CW-1:0]        slot_wcnt [NUM_SLOTS],
  input  logic [CW-1:0]        slot_acnt [NUM_SLOTS],
  output logic                 hazard,
  output logic [1:0]           sel
);
  logic          found, hit_ld;
  logic [CW-1:0] hit_w, hit_a;

  // youngest matching producer wins: scan from slot 0 upward
  always_comb begin
    found  = 1'b0;
    hit_ld = 1'b0;
    hit_w  = '0;
    hit_a  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!found && slot_wr[s] && (slot_dst[s] == src)) begin
        found  = 1'b1;
        hit_ld = slot_ld[s];
        hit_w  = slot_wcnt[s];
        hit_a  = slot_acnt[s];
      end
    end
    if (!used || (src == '0)) found = 1'b0;
  end

  always_comb begin
    hazard = 1'b0;
    sel    = SEL_RF;
    if (found) begin
      if (bypass_en) begin
        hazard = late ? (hit_a > 3'd2) : (hit_a > 3'd1);
        if (hit_w != '0) sel = hit_ld ? SEL_LOAD : SEL_ALU;
      end else begin
        hazard = (hit_w != '0);
      end
    end
  end

  AST_SEL_RF_WITHOUT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> (sel == SEL_RF)); // R11
endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
  import ilk_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_class,
  input  logic [REG_AW-1:0] in_src_a,
  input  logic [REG_AW-1:0] in_src_b,
  input  logic [REG_AW-1:0] in_dst,
  output logic              stall,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  localparam int NOPS = 2;

  logic [NUM_SLOTS-1:0] slot_wr, slot_ld;
  logic [REG_AW-1:0]    slot_dst  [NUM_SLOTS];
  logic [CW-1:0]        slot_wcnt [NUM_SLOTS];
  logic [CW-1:0]        slot_acnt [NUM_SLOTS];
  logic                 r_valid, issue;

  logic [NOPS-1:0]   op_used, op_late, op_haz;
  logic [REG_AW-1:0] op_src [NOPS];
  logic [1:0]        op_sel [NOPS];

  assign op_src[0]  = in_src_a;
  assign op_src[1]  = in_src_b;
  assign op_used[0] = (in_class != CL_NOP);
  assign op_used[1] = (in_class == CL_ADD) || (in_class == CL_STORE);
  assign op_late[0] = 1'b0;
  assign op_late[1] = (in_class == CL_STORE);

  ilk_track #(.REG_AW(REG_AW)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(issue), .in_class(in_class), .in_dst(in_dst),
    .slot_wr(slot_wr), .slot_ld(slot_ld), .slot_dst(slot_dst),
    .slot_wcnt(slot_wcnt), .slot_acnt(slot_acnt), .r_valid(r_valid)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    ilk_opchk #(.REG_AW(REG_AW)) u_chk (
      .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
      .used(op_used[k]), .late(op_late[k]), .src(op_src[k]),
      .slot_wr(slot_wr), .slot_ld(slot_ld), .slot_dst(slot_dst),
      .slot_wcnt(slot_wcnt), .slot_acnt(slot_acnt),
      .hazard(op_haz[k]), .sel(op_sel[k])
    );
  end

  assign stall    = in_valid && (|op_haz);
  assign in_ready = !stall;
  assign issue    = in_valid && !stall;
  assign sel_a    = op_sel[0];
  assign sel_b    = op_sel[1];

  // length of the current stall run, for the bound check
  logic [2:0] stall_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stall_run <= '0;
    else if (stall) stall_run <= (stall_run == 3'd7) ? stall_run : stall_run + 3'd1;
    else            stall_run <= '0;
  end

  AST_STALL_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_run < 3'd4)); // R3
  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !r_valid); // R12
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall); // R12
  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_src_a == '0 && in_src_b == '0) |-> !stall); // R7
endmodule

// File: tb/ilk_unit_tb.sv
module ilk_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready, stall;
  logic [1:0] in_class = 2'd0;
  logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [1:0] sel_a, sel_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ilk_unit #(.REG_AW(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
  );

  typedef struct packed {
    logic       mode;
    logic [1:0] pc;
    logic [4:0] pd;
    logic [1:0] gap;
    logic [1:0] cc;
    logic [4:0] ca;
    logic [4:0] cb;
    logic [2:0] st;
    logic [1:0] sa;
    logic [1:0] sb;
  } vec_t;

  localparam int NV = 15;
  // mode, producer class, producer dst, gap, consumer class, src a, src b, stalls, sel a, sel b
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 5'd1, 2'd0, 2'd1, 5'd1, 5'd5, 3'd2, 2'd0, 2'd0}, // R2
    '{1'b0, 2'd2, 5'd1, 2'd0, 2'd1, 5'd1, 5'd3, 3'd4, 2'd0, 2'd0}, // R3 R11
    '{1'b0, 2'd2, 5'd1, 2'd0, 2'd3, 5'd3, 5'd1, 3'd4, 2'd0, 2'd0}, // R3 store data
    '{1'b1, 2'd1, 5'd1, 2'd0, 2'd1, 5'd1, 5'd5, 3'd0, 2'd1, 2'd0}, // R4
    '{1'b1, 2'd1, 5'd1, 2'd0, 2'd1, 5'd5, 5'd1, 3'd0, 2'd0, 2'd1}, // R4 operand b
    '{1'b1, 2'd1, 5'd1, 2'd0, 2'd2, 5'd1, 5'd0, 3'd0, 2'd1, 2'd0}, // R4 load address
    '{1'b1, 2'd2, 5'd1, 2'd0, 2'd1, 5'd1, 5'd3, 3'd2, 2'd2, 2'd0}, // R5
    '{1'b1, 2'd2, 5'd1, 2'd0, 2'd3, 5'd3, 5'd1, 3'd1, 2'd0, 2'd2}, // R6 data
    '{1'b1, 2'd2, 5'd1, 2'd0, 2'd3, 5'd1, 5'd3, 3'd2, 2'd2, 2'd0}, // R6 address
    '{1'b1, 2'd2, 5'd0, 2'd0, 2'd1, 5'd0, 5'd0, 3'd0, 2'd0, 2'd0}, // R7
    '{1'b0, 2'd1, 5'd0, 2'd0, 2'd1, 5'd0, 5'd7, 3'd0, 2'd0, 2'd0}, // R7
    '{1'b0, 2'd2, 5'd1, 2'd2, 2'd1, 5'd1, 5'd3, 3'd2, 2'd0, 2'd0}, // R9
    '{1'b1, 2'd2, 5'd1, 2'd1, 2'd1, 5'd1, 5'd3, 3'd1, 2'd2, 2'd0}, // R9
    '{1'b0, 2'd3, 5'd1, 2'd0, 2'd1, 5'd1, 5'd3, 3'd0, 2'd0, 2'd0}, // R10 store
    '{1'b0, 2'd0, 5'd1, 2'd0, 2'd1, 5'd1, 5'd1, 3'd0, 2'd0, 2'd0}  // R10 no-op
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; returns at a negedge with in_valid low
  task automatic send(input logic [1:0] cls, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, output int st, output int sa, output int sb);
    in_valid = 1'b1; in_class = cls; in_src_a = a; in_src_b = b; in_dst = d;
    st = 0;
    #1;
    while (stall && st < 10) begin
      if (in_ready) begin
        fails++; checks++;
        $display("FAIL R12: actual in_ready 1 expected 0 during stall");
      end
      st++;
      @(negedge clk); #1;
    end
    sa = sel_a; sb = sel_b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flush(input logic mode);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    bypass_en = mode;
  endtask

  initial begin
    int st, sa, sb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    in_valid = 1'b1; in_class = 2'd1; in_src_a = 5'd1; in_src_b = 5'd2; in_dst = 5'd3;
    #1;
    check("R1 stall", stall, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 sel_a", sel_a, 0);
    check("R1 sel_b", sel_b, 0);
    @(negedge clk);
    in_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      flush(VEC[i].mode);
      send(VEC[i].pc, 5'd0, 5'd0, VEC[i].pd, st, sa, sb);
      repeat (VEC[i].gap) @(negedge clk);
      send(VEC[i].cc, VEC[i].ca, VEC[i].cb, 5'd9, st, sa, sb);
      check($sformatf("vector %0d stalls", i), st, VEC[i].st);
      check($sformatf("vector %0d sel_a", i), sa, VEC[i].sa);
      check($sformatf("vector %0d sel_b", i), sb, VEC[i].sb);
    end

    // R8: youngest producer decides, bypass on
    flush(1'b1);
    send(2'd2, 5'd0, 5'd0, 5'd1, st, sa, sb);
    send(2'd1, 5'd2, 5'd3, 5'd1, st, sa, sb);
    send(2'd1, 5'd1, 5'd5, 5'd4, st, sa, sb);
    check("R8 bypass stalls", st, 0);
    check("R8 bypass sel_a", sa, 1);
    // R8: youngest producer decides, bypass off
    flush(1'b0);
    send(2'd2, 5'd0, 5'd0, 5'd1, st, sa, sb);
    send(2'd1, 5'd2, 5'd3, 5'd1, st, sa, sb);
    send(2'd1, 5'd1, 5'd5, 5'd4, st, sa, sb);
    check("R8 no-bypass stalls", st, 2);

    // R12: no stall while in_valid is low, even with a pending hazard
    flush(1'b0);
    send(2'd2, 5'd0, 5'd0, 5'd1, st, sa, sb);
    in_class = 2'd1; in_src_a = 5'd1; in_src_b = 5'd1;
    #1;
    check("R12 idle stall", stall, 0);
    check("R12 idle in_ready", in_ready, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule